// File: doc/BRIEF.md
# Prioritized Pending Interrupt Selector

This block serves one processing element. It looks at a bank of interrupt sources and finds the single best candidate to signal. Each source carries a pending input, an enable bit, a group bit and an 8-bit priority. The block keeps only the upper `PRIO_BITS` bits of every priority. A combinational comparison tree picks the candidate with the numerically smallest priority. When two candidates have the same priority, the lower ID wins.

The winner then passes through two gates. The first is a priority mask, which removes any candidate that is not strictly more urgent than the mask. The second is a preemption test on the group-priority field, the part of the priority that lies above a binary point. The block reports the winner's ID, its priority and an interrupt-request flag, all registered once per cycle. When nothing qualifies, it reports ID 1023, meaning spurious. Software sets the per-source fields and the three global settings through a single-cycle write port.

The block has no state machine. It has one register stage for the configuration and one for the result. Source `i` always carries interrupt ID `i`.

Top module: `psel_top`

## Requirements
- R1: During and right after reset, `hp_id` is 1023, `hp_prio` is 8'hFF and `hp_irq` is 0. All enables are 0, group enables are 0, the mask is 0 and the binary point is 0.
- R2: A source is a candidate only when all of the following hold:
  - its `pend` bit is 1;
  - its enable bit is 1;
  - the group-enable bit picked by its group bit is 1 (group-enable bit 0 serves group 0, bit 1 serves group 1).
- R3: Among the candidates, the one with the numerically smallest stored priority wins.
- R4: When the stored priorities are equal, the lowest interrupt ID wins.
- R5: Every priority and mask value is stored with its low `8-PRIO_BITS` bits forced to zero. With `PRIO_BITS`=4, raw values 0x05 and 0x0A both count as level 0x00, and `hp_prio` shows the stored value.
- R6: A winner whose stored priority is not strictly below the stored mask is dropped. The output then reads 1023 / 8'hFF / 0.
- R7: The interrupt request depends on the binary point `bp`. The group field is priority bits [7:bp+1], with the rest zeroed. `hp_irq` is 1 when either condition holds:
  - `run_prio` is 8'hFF (idle) and a winner survives the mask;
  - the winner's group field is strictly below the group field of `run_prio`.
  A winner that survives the mask but fails the preemption test is still reported with `hp_irq`=0.
- R8: When there is no candidate, the output is ID 1023, priority 8'hFF and `hp_irq`=0.
- R9: Outputs follow the inputs sampled at the previous rising edge, through exactly one register. A write takes effect on the outputs at the second edge after it is presented.
- R10: A write is accepted when `wr_en`=1. The kind of write is given by `wr_kind`, and data bits are taken from `wr_data` as listed below. A per-source write whose `wr_idx` is ≥ `NUM_SRC` changes nothing.

  | `wr_kind` | Meaning | Data used |
  |---|---|---|
  | 0 | source priority | `wr_data[7:0]` |
  | 1 | source enable | `wr_data[0]` |
  | 2 | source group | `wr_data[0]` |
  | 3 | mask | `wr_data[7:0]` |
  | 4 | binary point | `wr_data[2:0]` |
  | 5 | group enables | `wr_data[1:0]` |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 3 | Write kind (encoding in R10) |
| wr_idx | input | IDX_W | Source index for per-source writes |
| wr_data | input | 8 | Write data |
| pend | input | NUM_SRC | Pending level per source |
| run_prio | input | 8 | Running priority of the processing element, 8'hFF when idle |
| hp_id | output | 10 | Winning interrupt ID, or 1023 |
| hp_prio | output | 8 | Winning stored priority, or 8'hFF |
| hp_irq | output | 1 | Interrupt request |

## Verification
Several properties are checked by assertions on every cycle:
- a spurious result never carries a request or a real priority;
- a reported ID is in range and was pending on the previous cycle;
- a reported priority has its unimplemented bits at zero;
- a request always beats both the previous mask and the group field of the previous running priority.

Other behaviours appear only through the bench's scenarios, which compare against a reference model: which source wins among several, the lowest-ID tie-break, group-enable filtering, ignored out-of-range writes and the exact two-edge write latency.

// File: rtl/psel_pkg.sv
package psel_pkg;

    typedef enum logic [2:0] {
        WK_PRIO   = 3'd0,
        WK_ENABLE = 3'd1,
        WK_GROUP  = 3'd2,
        WK_MASK   = 3'd3,
        WK_BPOINT = 3'd4,
        WK_GRPEN  = 3'd5
    } wr_kind_e;

    localparam logic [9:0] SPURIOUS_ID = 10'd1023;

    typedef struct packed {
        logic       vld;
        logic [7:0] prio;
        logic [9:0] id;
    } cand_t;

endpackage

// File: rtl/psel_cfg.sv
module psel_cfg
    import psel_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int PRIO_BITS = 4,
    parameter int IDX_W     = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [2:0]             wr_kind,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [7:0]             wr_data,
    output logic [NUM_SRC*8-1:0]   prio_flat,
    output logic [NUM_SRC-1:0]     en_vec,
    output logic [NUM_SRC-1:0]     grp_vec,
    output logic [7:0]             mask_q,
    output logic [2:0]             bp_q,
    output logic [1:0]             grpen_q
);

    localparam logic [7:0] KEEP = ~(8'hFF >> PRIO_BITS);

    wr_kind_e kind;
    assign kind = wr_kind_e'(wr_kind);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_flat <= '0;
            en_vec    <= '0;
            grp_vec   <= '0;
            mask_q    <= '0;
            bp_q      <= '0;
            grpen_q   <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    if (kind == WK_PRIO)   prio_flat[i*8 +: 8] <= wr_data & KEEP;
                    if (kind == WK_ENABLE) en_vec[i]  <= wr_data[0];
                    if (kind == WK_GROUP)  grp_vec[i] <= wr_data[0];
                end
            end
            if (kind == WK_MASK)   mask_q  <= wr_data & KEEP;
            if (kind == WK_BPOINT) bp_q    <= wr_data[2:0];
            if (kind == WK_GRPEN)  grpen_q <= wr_data[1:0];
        end
    end

endmodule

// File: rtl/psel_tree.sv
module psel_tree
    import psel_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0]   leaf_vld,
    input  logic [NUM_SRC*8-1:0] leaf_prio,
    output cand_t                win
);

    localparam int LVL = (NUM_SRC < 2) ? 1 : $clog2(NUM_SRC);
    localparam int P   = 1 << LVL;

    logic [P-1:0]   vld_pad;
    logic [P*8-1:0] prio_pad;
    cand_t          node [2*P-1];

    assign vld_pad  = P'(leaf_vld);
    assign prio_pad = (P*8)'(leaf_prio);

    always_comb begin
        for (int i = 0; i < P; i++) begin
            node[P-1+i].vld  = vld_pad[i];
            node[P-1+i].prio = prio_pad[i*8 +: 8];
            node[P-1+i].id   = 10'(i);
        end
        for (int k = P - 2; k >= 0; k--) begin
            if (node[2*k+1].vld &&
                (!node[2*k+2].vld || node[2*k+1].prio <= node[2*k+2].prio))
                node[k] = node[2*k+1];
            else
                node[k] = node[2*k+2];
        end
    end

    assign win = node[0];

endmodule

// File: rtl/psel_gate.sv
module psel_gate
    import psel_pkg::*;
(
    input  cand_t       win,
    input  logic [7:0]  mask,
    input  logic [2:0]  bp,
    input  logic [7:0]  run_prio,
    output logic [9:0]  nxt_id,
    output logic [7:0]  nxt_prio,
    output logic        nxt_irq
);

    logic [7:0] grp_mask;
    logic       pass;

    assign grp_mask = 8'hFF << ({1'b0, bp} + 4'd1);
    assign pass     = win.vld && (win.prio < mask);

    always_comb begin
        nxt_id   = pass ? win.id   : SPURIOUS_ID;
        nxt_prio = pass ? win.prio : 8'hFF;
        nxt_irq  = pass && ((run_prio == 8'hFF) ||
                            ((win.prio & grp_mask) < (run_prio & grp_mask)));
    end

endmodule

// File: rtl/psel_top.sv
module psel_top
    import psel_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int PRIO_BITS = 4,
    parameter int IDX_W     = $clog2(NUM_SRC) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_kind,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [7:0]         run_prio,
    output logic [9:0]         hp_id,
    output logic [7:0]         hp_prio,
    output logic               hp_irq
);

    logic [NUM_SRC*8-1:0] cfg_prio;
    logic [NUM_SRC-1:0]   cfg_en;
    logic [NUM_SRC-1:0]   cfg_grp;
    logic [7:0]           cfg_mask;
    logic [2:0]           cfg_bp;
    logic [1:0]           cfg_grpen;
    logic [NUM_SRC-1:0]   cand_vld;
    cand_t                win;
    logic [9:0]           nxt_id;
    logic [7:0]           nxt_prio;
    logic                 nxt_irq;

    psel_cfg #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS), .IDX_W(IDX_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .prio_flat(cfg_prio),
        .en_vec(cfg_en), .grp_vec(cfg_grp), .mask_q(cfg_mask),
        .bp_q(cfg_bp), .grpen_q(cfg_grpen)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_qual
        assign cand_vld[g] = pend[g] & cfg_en[g] & cfg_grpen[cfg_grp[g]];
    end

    psel_tree #(.NUM_SRC(NUM_SRC)) tree_i (
        .leaf_vld(cand_vld), .leaf_prio(cfg_prio), .win(win)
    );

    psel_gate gate_i (
        .win(win), .mask(cfg_mask), .bp(cfg_bp), .run_prio(run_prio),
        .nxt_id(nxt_id), .nxt_prio(nxt_prio), .nxt_irq(nxt_irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hp_id   <= SPURIOUS_ID;
            hp_prio <= 8'hFF;
            hp_irq  <= 1'b0;
        end else begin
            hp_id   <= nxt_id;
            hp_prio <= nxt_prio;
            hp_irq  <= nxt_irq;
        end
    end

endmodule

// File: rtl/psel_chk.sv
module psel_chk #(
    parameter int NUM_SRC   = 32,
    parameter int PRIO_BITS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] pend,
    input logic [7:0]         run_prio,
    input logic [2:0]         bp,
    input logic [7:0]         mask,
    input logic [9:0]         hp_id,
    input logic [7:0]         hp_prio,
    input logic               hp_irq
);

    localparam logic [7:0] LOW = 8'hFF >> PRIO_BITS;

    logic [NUM_SRC-1:0] pend_d;
    always_ff @(posedge clk) pend_d <= pend;

    function automatic logic [7:0] grp_of(logic [7:0] p, logic [2:0] b);
        return p & (8'hFF << ({1'b0, b} + 4'd1));
    endfunction

    AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_id == 10'd1023) |-> (!hp_irq && hp_prio == 8'hFF)); // R8
    AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_id < 10'(NUM_SRC)) || (hp_id == 10'd1023)); // R3
    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_id < 10'(NUM_SRC)) |-> pend_d[hp_id]); // R2
    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_id != 10'd1023) |-> ((hp_prio & LOW) == 8'h00)); // R5
    AST_BELOW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_id != 10'd1023) |-> (hp_prio < $past(mask))); // R6
    AST_PREEMPT_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        hp_irq |-> ($past(run_prio) == 8'hFF ||
                    grp_of(hp_prio, $past(bp)) < grp_of($past(run_prio), $past(bp)))); // R7

endmodule

bind psel_top psel_chk #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS)) chk_i (
    .clk(clk), .rst_n(rst_n), .pend(pend), .run_prio(run_prio),
    .bp(cfg_bp), .mask(cfg_mask), .hp_id(hp_id), .hp_prio(hp_prio), .hp_irq(hp_irq)
);

// File: tb/psel_top_tb_top.sv
module psel_top_tb_top;

    localparam int N     = 32;
    localparam int PB    = 4;
    localparam int IW    = $clog2(N) + 1;
    localparam logic [7:0] KEEP = ~(8'hFF >> PB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_kind = '0;
    logic [IW-1:0] wr_idx = '0;
    logic [7:0]    wr_data = '0;
    logic [N-1:0]  pend = '0;
    logic [7:0]    run_prio = 8'hFF;
    logic [9:0]    hp_id;
    logic [7:0]    hp_prio;
    logic          hp_irq;

    int total = 0;
    int bad   = 0;

    logic [7:0] m_prio [N];
    logic [N-1:0] m_en = '0, m_grp = '0;
    logic [7:0] m_mask = '0;
    logic [2:0] m_bp = '0;
    logic [1:0] m_grpen = '0;

    always #10 clk = ~clk;

    psel_top #(.NUM_SRC(N), .PRIO_BITS(PB)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .pend(pend), .run_prio(run_prio),
        .hp_id(hp_id), .hp_prio(hp_prio), .hp_irq(hp_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int kind, input int idx, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = 3'(kind); wr_idx = IW'(idx); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
        if (kind == 0 && idx < N) m_prio[idx] = 8'(data) & KEEP;
        if (kind == 1 && idx < N) m_en[idx]  = data[0];
        if (kind == 2 && idx < N) m_grp[idx] = data[0];
        if (kind == 3) m_mask  = 8'(data) & KEEP;
        if (kind == 4) m_bp    = data[2:0];
        if (kind == 5) m_grpen = data[1:0];
    endtask

    function automatic logic [7:0] gf(logic [7:0] p);
        return p & (8'hFF << ({1'b0, m_bp} + 4'd1));
    endfunction

    task automatic expect_out(input string tag);
        int best = -1;
        logic [7:0] bp8 = 8'hFF;
        int eid; int ep; int eirq;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            if (pend[i] && m_en[i] && m_grpen[m_grp[i]] && (best < 0 || m_prio[i] < bp8)) begin
                best = i; bp8 = m_prio[i];
            end
        end
        if (best >= 0 && bp8 < m_mask) begin
            eid = best; ep = bp8;
            eirq = (run_prio == 8'hFF || gf(bp8) < gf(run_prio)) ? 1 : 0;
        end else begin
            eid = 1023; ep = 255; eirq = 0;
        end
        chk({tag, " id"}, hp_id, eid);
        chk({tag, " prio"}, hp_prio, ep);
        chk({tag, " irq"}, hp_irq, eirq);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) m_prio[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 reset id", hp_id, 1023);
        chk("R1 reset prio", hp_prio, 255);
        chk("R1 reset irq", hp_irq, 0);
        rst_n = 1'b1;
        pend = '1;
        expect_out("R1 all disabled after reset");

        wr(5, 0, 3); wr(3, 0, 8'hFF);
        wr(1, 7, 1); wr(0, 7, 8'h47);
        pend = 32'h80;
        expect_out("R2 single source");
        wr(2, 7, 1); wr(5, 0, 1);
        expect_out("R2 group disabled");
        wr(5, 0, 3);
        wr(1, 3, 1); wr(0, 3, 8'h20); pend = 32'h88;
        expect_out("R3 lower value wins");
        wr(0, 3, 8'h4A);
        expect_out("R4 tie lowest id");
        wr(0, 3, 8'h05); wr(1, 9, 1); wr(0, 9, 8'h0A); pend = 32'h288;
        expect_out("R5 reduced to zero");
        chk("R5 reduced level", hp_prio, 0);
        chk("R4 tie after reduction", hp_id, 3);
        wr(3, 0, 8'h0C); pend = 32'h80;
        expect_out("R6 masked out");
        chk("R6 spurious id", hp_id, 1023);
        wr(3, 0, 8'hFF);
        wr(4, 0, 3); run_prio = 8'h40;
        expect_out("R7 equal group no irq");
        chk("R7 reported without irq", hp_id, 7);
        run_prio = 8'h50;
        expect_out("R7 higher group irq");
        wr(4, 0, 7); run_prio = 8'hFF;
        expect_out("R7 idle irq");
        pend = '0;
        expect_out("R8 nothing pending");
        wr(0, 40, 0); pend = 32'h80;
        expect_out("R10 out of range write");
        @(negedge clk); pend = 32'h08;
        @(posedge clk); @(negedge clk);
        chk("R9 one edge latency", hp_id, 3);

        for (int it = 0; it < 400; it++) begin
            int nw = $urandom_range(0, 4);
            for (int w = 0; w < nw; w++)
                wr($urandom_range(0, 5), $urandom_range(0, N - 1), $urandom_range(0, 255));
            pend = $urandom;
            run_prio = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
            expect_out("R3 R7 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule